// File: doc/BRIEF.md
# Broadcast serial configuration port

This block is the configuration slave of a cascadable display column driver. A controller shares one serial clock and one bidirectional data line among every driver on a board. Each write frame updates the addressed register in all drivers at once. A read frame is answered only by the driver whose master-select input is high; every other driver keeps the line released.

A frame is a run of at least fourteen ones, then a two-bit delimiter (`00` write, `01` read), a six-bit address sent MSB first, a turnaround bit, a bus-release bit and eight data bits sent MSB first. The port samples the line on the rising serial clock edge and drives read data on the falling edge. It holds a 64-address map, of which addresses 0, 1 and 3 to 10 are storage. Address 2 reads back an external converter result. The register contents leave the block as plain output words.

The block also carries the master-select chain. Its master output copies the master input on each rising edge of latch enable, unless the freeze bit of the control register is set.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset every register output, `sdata_oe` and `master_out` are zero.
- R2: A write frame (at least 14 ones, delimiter bits 0 then 0, address MSB first, two turnaround bits, 8 data bits MSB first) stores the data in the addressed register. The store happens at the rising edge that samples the last data bit. Address 0 is scratch storage, address 1 is `cfg_ctrl`, and addresses 6, 7 and 8 are `pre_lvl[0..2]`, each storing 8 bits.
- R3: Addresses 3, 4 and 5 store only data bits 4..0 into `cur_mag[0..2]`. Address 9 stores bits 2..0 into `pre_cnt`. Address 10 stores bits 3..0 into `adc_sel`. Reads of these addresses return the stored field with the upper bits zero.
- R4: A delimiter preceded by fewer than 14 consecutive ones is ignored: no register changes. A correct frame that follows is decoded normally.
- R5: On a read frame (delimiter 0 then 1) with `master_in` high, the port drives the 8 data bits MSB first, each changing on a falling edge ahead of its sampling rising edge. `sdata_oe` is high for exactly those 8 bit periods.
- R6: On a read frame with `master_in` low, `sdata_oe` stays low for the whole frame. No read frame changes any register.
- R7: A read of address 2 returns `adc_result` as sampled during the turnaround bit. A read of addresses 11 to 63 returns 0. Writes to address 2 or to addresses 11 to 63 change no register.
- R8: On each rising edge of `latch_en`, `master_out` takes `master_in` when `cfg_ctrl` bit 7 (freeze) is 0, and holds its value when that bit is 1.
- R9: A reset asserted in the middle of a frame clears every register and returns the decoder to preamble search, so that the next full frame after release is decoded correctly.
- R10: A preamble longer than 14 ones is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_in | input | 1 | Serial data line as seen at the pad |
| sdata_out | output | 1 | Read data driven onto the line |
| sdata_oe | output | 1 | Drive enable for the data line |
| master_in | input | 1 | Master-select input of the chain |
| latch_en | input | 1 | Latch enable; clocks the master chain |
| master_out | output | 1 | Master-select output to the next driver |
| adc_result | input | 8 | Converter result returned at address 2 |
| cfg_ctrl | output | 8 | Control register; bit 7 freeze, bit 6 precharge off, bit 5 run, bit 4 short mode, bit 3 color, bit 2 bus mode, bits 1..0 test |
| cur_mag | output | 3x5 | Current magnitude of banks A, B, C |
| pre_lvl | output | 3x8 | Precharge level of banks A, B, C |
| pre_cnt | output | 3 | Precharge duration count |
| adc_sel | output | 4 | Converter source select |

## Verification
A write lands at the rising edge that samples its eighth data bit. The bench therefore compares the register ports two idle bit periods after that edge, when no further edge can move them. A read bit is driven on the falling edge before its sampling edge, so the bench samples `sdata_out` and `sdata_oe` two nanoseconds after each falling edge. It counts enabled periods over the whole frame, which pins the enable window to exactly eight bits. The master output changes on the latch edge itself, so it is checked one nanosecond after each latch pulse.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [2:0] {
    ST_PRE,
    ST_SFD,
    ST_ADDR,
    ST_TA,
    ST_BT,
    ST_DATA
  } cfg_state_e;

  localparam int ADR_SCRATCH = 0;
  localparam int ADR_CTRL    = 1;
  localparam int ADR_ADC     = 2;
  localparam int ADR_CUR     = 3;
  localparam int ADR_PRE     = 6;
  localparam int ADR_PCNT    = 9;
  localparam int ADR_SEL     = 10;
endpackage

// File: rtl/cfg_frame_decoder.sv
module cfg_frame_decoder
  import cfg_port_pkg::*;
#(
  parameter int PRE_LEN = 14,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  output logic              wr_en,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_load,
  output logic              in_data,
  output logic              is_read
);
  localparam int OW   = $clog2(PRE_LEN + 1);
  localparam int BITS = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CW   = $clog2(BITS);

  cfg_state_e        state_q, state_d;
  logic [OW-1:0]     ones_q, ones_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-2:0] data_q, data_d;
  logic              rd_q, rd_d;

  always_comb begin
    state_d = state_q;
    ones_d  = ones_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    data_d  = data_q;
    rd_d    = rd_q;
    case (state_q)
      ST_PRE: begin
        if (sdi) begin
          if (ones_q != OW'(PRE_LEN)) ones_d = ones_q + 1'b1;
        end else begin
          if (ones_q == OW'(PRE_LEN)) state_d = ST_SFD;
          ones_d = '0;
        end
      end
      ST_SFD: begin
        rd_d    = sdi;
        cnt_d   = '0;
        state_d = ST_ADDR;
      end
      ST_ADDR: begin
        addr_d = {addr_q[ADDR_W-2:0], sdi};
        if (cnt_q == CW'(ADDR_W - 1)) begin
          cnt_d   = '0;
          state_d = ST_TA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TA: state_d = ST_BT;
      ST_BT: begin
        cnt_d   = '0;
        state_d = ST_DATA;
      end
      ST_DATA: begin
        data_d = {data_q[DATA_W-3:0], sdi};
        if (cnt_q == CW'(DATA_W - 1)) begin
          cnt_d   = '0;
          state_d = ST_PRE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_PRE;
        ones_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PRE;
      ones_q  <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ones_q  <= ones_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      rd_q    <= rd_d;
    end
  end

  assign in_data = (state_q == ST_DATA);
  assign is_read = rd_q;
  assign addr    = addr_q;
  assign wr_data = {data_q, sdi};
  assign wr_en   = in_data && !rd_q && (cnt_q == CW'(DATA_W - 1));
  assign rd_load = (state_q == ST_TA) && rd_q;

  // R2: a write strobe is a single edge; frames cannot be back to back
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R4: preamble counter never exceeds its saturation value
  a_r4_ones_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= OW'(PRE_LEN));

  // R4: a zero seen after a short run of ones keeps the search going
  a_r4_short_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE && !sdi && ones_q != OW'(PRE_LEN)) |=> state_q == ST_PRE);
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int NBANK  = 3,
  parameter int CUR_W  = 5,
  parameter int PCNT_W = 3,
  parameter int SEL_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [DATA_W-1:0]            adc_result,
  output logic [DATA_W-1:0]            rd_data,
  output logic [DATA_W-1:0]            ctrl,
  output logic [NBANK-1:0][CUR_W-1:0]  cur_mag,
  output logic [NBANK-1:0][DATA_W-1:0] pre_lvl,
  output logic [PCNT_W-1:0]            pre_cnt,
  output logic [SEL_W-1:0]             adc_sel
);
  logic [DATA_W-1:0]            scratch_q, ctrl_q;
  logic [NBANK-1:0][CUR_W-1:0]  cur_q;
  logic [NBANK-1:0][DATA_W-1:0] pre_q;
  logic [PCNT_W-1:0]            pcnt_q;
  logic [SEL_W-1:0]             sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      ctrl_q    <= '0;
      pcnt_q    <= '0;
      sel_q     <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(ADR_SCRATCH)) scratch_q <= wr_data;
      if (addr == ADDR_W'(ADR_CTRL))    ctrl_q    <= wr_data;
      if (addr == ADDR_W'(ADR_PCNT))    pcnt_q    <= wr_data[PCNT_W-1:0];
      if (addr == ADDR_W'(ADR_SEL))     sel_q     <= wr_data[SEL_W-1:0];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q[b] <= '0;
        pre_q[b] <= '0;
      end else if (wr_en) begin
        if (addr == ADDR_W'(ADR_CUR + b)) cur_q[b] <= wr_data[CUR_W-1:0];
        if (addr == ADDR_W'(ADR_PRE + b)) pre_q[b] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(ADR_SCRATCH)) rd_data = scratch_q;
    if (addr == ADDR_W'(ADR_CTRL))    rd_data = ctrl_q;
    if (addr == ADDR_W'(ADR_ADC))     rd_data = adc_result;
    if (addr == ADDR_W'(ADR_PCNT))    rd_data = DATA_W'(pcnt_q);
    if (addr == ADDR_W'(ADR_SEL))     rd_data = DATA_W'(sel_q);
    for (int b = 0; b < NBANK; b++) begin
      if (addr == ADDR_W'(ADR_CUR + b)) rd_data = DATA_W'(cur_q[b]);
      if (addr == ADDR_W'(ADR_PRE + b)) rd_data = pre_q[b];
    end
  end

  assign ctrl    = ctrl_q;
  assign cur_mag = cur_q;
  assign pre_lvl = pre_q;
  assign pre_cnt = pcnt_q;
  assign adc_sel = sel_q;

  // R6: storage moves only on a write strobe from the decoder
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(scratch_q) && $stable(ctrl_q) && $stable(cur_q) &&
                $stable(pre_q) && $stable(pcnt_q) && $stable(sel_q)));

  // R7: a write to the result address or the unused range touches nothing
  a_r7_no_side_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == ADDR_W'(ADR_ADC) || addr > ADDR_W'(ADR_SEL))) |=>
      ($stable(scratch_q) && $stable(ctrl_q) && $stable(cur_q) &&
       $stable(pre_q) && $stable(pcnt_q) && $stable(sel_q)));
endmodule

// File: rtl/cfg_master_chain.sv
module cfg_master_chain (
  input  logic latch_en,
  input  logic rst_n,
  input  logic freeze,
  input  logic master_in,
  output logic master_out
);
  logic mo_q;

  always_ff @(posedge latch_en or negedge rst_n) begin
    if (!rst_n)       mo_q <= 1'b0;
    else if (!freeze) mo_q <= master_in;
  end

  assign master_out = mo_q;

  // R8: frozen chain keeps its output across a latch edge
  a_r8_frozen_hold: assert property (@(posedge latch_en) disable iff (!rst_n)
    freeze |=> $stable(master_out));

  // R8: unfrozen chain passes the input sampled at the latch edge
  a_r8_follow: assert property (@(posedge latch_en) disable iff (!rst_n)
    !freeze |=> master_out == $past(master_in));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int PRE_LEN = 14,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int NBANK   = 3,
  parameter int CUR_W   = 5,
  parameter int PCNT_W  = 3,
  parameter int SEL_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sdata_in,
  output logic                         sdata_out,
  output logic                         sdata_oe,
  input  logic                         master_in,
  input  logic                         latch_en,
  output logic                         master_out,
  input  logic [DATA_W-1:0]            adc_result,
  output logic [DATA_W-1:0]            cfg_ctrl,
  output logic [NBANK-1:0][CUR_W-1:0]  cur_mag,
  output logic [NBANK-1:0][DATA_W-1:0] pre_lvl,
  output logic [PCNT_W-1:0]            pre_cnt,
  output logic [SEL_W-1:0]             adc_sel
);
  localparam int FREEZE_BIT = DATA_W - 1;

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              wr_en, rd_load, in_data, is_read;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [DATA_W-1:0] rd_sh_q, rd_sh_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  cfg_frame_decoder #(.PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .sdi     (sdata_in),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_load (rd_load),
    .in_data (in_data),
    .is_read (is_read)
  );

  cfg_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBANK(NBANK), .CUR_W(CUR_W),
                 .PCNT_W(PCNT_W), .SEL_W(SEL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .adc_result (adc_result),
    .rd_data    (rd_data),
    .ctrl       (cfg_ctrl),
    .cur_mag    (cur_mag),
    .pre_lvl    (pre_lvl),
    .pre_cnt    (pre_cnt),
    .adc_sel    (adc_sel)
  );

  cfg_master_chain u_chain (
    .latch_en   (latch_en),
    .rst_n      (rst_i_n),
    .freeze     (cfg_ctrl[FREEZE_BIT]),
    .master_in  (master_in),
    .master_out (master_out)
  );

  always_comb begin
    rd_sh_d = rd_sh_q;
    if (rd_load)                 rd_sh_d = rd_data;
    else if (in_data && is_read) rd_sh_d = {rd_sh_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rd_sh_q <= '0;
    else          rd_sh_q <= rd_sh_d;
  end

  always_ff @(negedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sdata_oe  <= 1'b0;
      sdata_out <= 1'b0;
    end else begin
      sdata_oe  <= in_data && is_read && master_in;
      sdata_out <= rd_sh_q[DATA_W-1];
    end
  end

  // R5: the line is only driven while a read frame is in its data phase
  a_r5_drive_window: assert property (@(posedge clk) disable iff (!rst_i_n)
    sdata_oe |-> (in_data && is_read));

  // R6: no write strobe ever occurs while the port is driving the line
  a_r6_no_write_while_driving: assert property (@(posedge clk) disable iff (!rst_i_n)
    sdata_oe |-> !wr_en);
endmodule

// File: tb/cfg_serial_port_bench.sv
module cfg_serial_port_bench;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             sdata_in, sdata_out, sdata_oe;
  logic             master_in, latch_en, master_out;
  logic [7:0]       adc_result, cfg_ctrl;
  logic [2:0][4:0]  cur_mag;
  logic [2:0][7:0]  pre_lvl;
  logic [2:0]       pre_cnt;
  logic [3:0]       adc_sel;

  int         n_tests = 0;
  int         n_fail  = 0;
  int         oe_hi;
  logic       last_out;
  logic [7:0] got;
  logic [7:0] mdl [0:63];
  bit         done = 1'b0;

  always #4 clk = ~clk;

  cfg_serial_port u_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .sdata_in(sdata_in), .sdata_out(sdata_out),
    .sdata_oe(sdata_oe), .master_in(master_in), .latch_en(latch_en),
    .master_out(master_out), .adc_result(adc_result), .cfg_ctrl(cfg_ctrl),
    .cur_mag(cur_mag), .pre_lvl(pre_lvl), .pre_cnt(pre_cnt), .adc_sel(adc_sel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_cyc(input logic b);
    @(negedge clk);
    sdata_in = b;
    #2;
    if (sdata_oe) oe_hi++;
    last_out = sdata_out;
    @(posedge clk);
  endtask

  task automatic frame(input logic rd, input logic [5:0] a, input logic [7:0] d, input int nones);
    oe_hi = 0;
    got   = 8'h00;
    for (int i = 0; i < nones; i++) bit_cyc(1'b1);
    bit_cyc(1'b0);
    bit_cyc(rd);
    for (int i = 5; i >= 0; i--) bit_cyc(a[i]);
    bit_cyc(1'b0);
    bit_cyc(1'b0);
    for (int i = 7; i >= 0; i--) begin
      bit_cyc(rd ? 1'b0 : d[i]);
      got[i] = last_out;
    end
    bit_cyc(1'b0);
    bit_cyc(1'b0);
  endtask

  function automatic void model_write(input int a, input logic [7:0] d);
    case (a)
      0, 1, 6, 7, 8: mdl[a] = d;
      3, 4, 5:       mdl[a] = d & 8'h1F;
      9:             mdl[a] = d & 8'h07;
      10:            mdl[a] = d & 8'h0F;
      default:       ;
    endcase
  endfunction

  function automatic string tag_for(input int a);
    if (a == 2 || a > 10) return "R7";
    if ((a >= 3 && a <= 5) || a == 9 || a == 10) return "R3";
    return "R2";
  endfunction

  task automatic check_ports(input string tag);
    check({tag, " ctrl"}, cfg_ctrl, mdl[1]);
    for (int b = 0; b < 3; b++) begin
      check({tag, " cur"}, cur_mag[b], mdl[3+b][4:0]);
      check({tag, " pre"}, pre_lvl[b], mdl[6+b]);
    end
    check({tag, " pcnt"}, pre_cnt, mdl[9][2:0]);
    check({tag, " sel"}, adc_sel, mdl[10][3:0]);
  endtask

  task automatic latch_pulse();
    @(negedge clk);
    latch_en = 1'b1;
    #1;
    latch_en = 1'b0;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sdata_in = 1'b0; master_in = 1'b0; latch_en = 1'b0; adc_result = 8'h00;
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    #30;
    // R1: reset state
    check_ports("R1");
    check("R1 oe", sdata_oe, 1'b0);
    check("R1 master_out", master_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) bit_cyc(1'b0);

    // R2 R3 R7 R10: sweep every address, write then read back
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 64; a++) begin
        logic [7:0] d;
        d = 8'((a * 29 + p * 113 + 7) & 255);
        frame(1'b0, 6'(a), d, (p == 0) ? 14 : 20);
        model_write(a, d);
        check_ports(p == 0 ? tag_for(a) : "R10");
      end
      master_in = 1'b1;
      for (int a = 0; a < 64; a++) begin
        logic [7:0] e;
        adc_result = 8'(a ^ 8'h5A ^ p);
        e = (a == 2) ? adc_result : mdl[a];
        frame(1'b1, 6'(a), 8'h00, 14);
        check({tag_for(a), " R5 read data"}, got, e);
        check("R5 oe periods", oe_hi, 8);
      end
      master_in = 1'b0;
    end

    // R6: reads by a non-master never drive and never change state
    for (int a = 0; a < 11; a++) begin
      frame(1'b1, 6'(a), 8'h00, 14);
      check("R6 oe periods", oe_hi, 0);
      check_ports("R6");
    end

    // R4: short preamble ignored, then a proper frame works
    frame(1'b0, 6'd1, ~mdl[1], 13);
    check_ports("R4");
    frame(1'b0, 6'd6, ~mdl[6], 13);
    check_ports("R4");
    frame(1'b0, 6'd6, 8'hC3, 14);
    model_write(6, 8'hC3);
    check_ports("R4 recover");

    // R8: master chain with and without freeze
    frame(1'b0, 6'd1, 8'h00, 14);
    model_write(1, 8'h00);
    master_in = 1'b1;
    latch_pulse();
    check("R8 follow high", master_out, 1'b1);
    master_in = 1'b0;
    latch_pulse();
    check("R8 follow low", master_out, 1'b0);
    master_in = 1'b1;
    frame(1'b0, 6'd1, 8'h80, 14);
    model_write(1, 8'h80);
    latch_pulse();
    check("R8 frozen", master_out, 1'b0);
    frame(1'b0, 6'd1, 8'h24, 14);
    model_write(1, 8'h24);
    latch_pulse();
    check("R8 unfrozen", master_out, 1'b1);
    master_in = 1'b0;

    // R9: reset in the middle of a frame
    for (int i = 0; i < 14; i++) bit_cyc(1'b1);
    bit_cyc(1'b0);
    bit_cyc(1'b0);
    bit_cyc(1'b1);
    bit_cyc(1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    check_ports("R9 cleared");
    check("R9 master_out", master_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) bit_cyc(1'b0);
    frame(1'b0, 6'd7, 8'h3C, 14);
    model_write(7, 8'h3C);
    check_ports("R9 after release");
    master_in = 1'b1;
    frame(1'b1, 6'd7, 8'h00, 14);
    check("R9 readback", got, 8'h3C);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule